// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

The block gives a small group of external event inputs a timestamp each. Every channel watches one asynchronous input. When that input shows the edge the channel is set to look for, the unit copies the current value of a shared free-running count into that channel's capture register. The count comes in as an input. A later step, such as software that subtracts two timestamps to get a pulse width, uses the stored values.

Each channel has a two-bit edge mode, an interrupt enable and a sticky event flag. Channels are grouped in pairs, and one control/status word holds the settings and flags of both channels of a pair. Each capture register can be read at its own address. Each input goes through a multi-stage synchronizer before edge detection, so the time from an input change to its capture is a fixed number of clocks.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset every capture register reads 0, every control word reads 0 (all modes disabled, enables 0, flags 0) and `irq` is all zeros.
- R2: In edge mode 01 a channel captures on a low-to-high transition of its input and ignores a high-to-low transition.
- R3: In edge mode 10 a channel captures on a high-to-low transition and ignores a low-to-high transition.
- R4: In edge mode 11 a channel captures on both transitions.
- R5: In edge mode 00 a channel never captures: its register stays unchanged and its flag is not set.
- R6: An input change made between two rising clock edges is captured at the third rising edge after it. The stored value is the `timebase` value present at that edge.
- R7: A capture sets the channel's flag. `irq[i]` is 1 exactly when channel i's flag and enable are both 1.
- R8: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. When a capture and a clearing write reach the same channel in the same clock, the flag ends up set.
- R9: A new capture overwrites the register even while the flag from an earlier capture is still set.
- R10: Map with the default configuration. Address 0 is the control word of channels 0/1 and address 1 that of channels 2/3. In a control word the lower channel uses bits 3:0 and the upper channel bits 7:4. Within each nibble, bits 1:0 are the mode, bit 2 the enable and bit 3 the flag. Bits 15:8 read 0.
- R11: Addresses 2 to 5 return the capture registers of channels 0 to 3. Writes to those addresses have no effect, and addresses 6 and 7 read 0.
- R12: Channels are independent: an edge on one channel changes no other channel's register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timebase | input | CNT_W (16) | Shared free-running count to be sampled |
| cap_in | input | NUM_CH (4) | Asynchronous event inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Register address |
| wdata | input | CNT_W (16) | Write data |
| rdata | output | CNT_W (16) | Read data for `addr` (combinational) |
| irq | output | NUM_CH (4) | Per-channel interrupt request |

## Verification
The hardest case to reach from the ports is a capture and a flag-clearing write landing in the same clock. The bench counts clocks from the moment it changes an input and raises the write strobe so that the write takes effect at exactly the third edge, when the capture happens. A sweep over every channel, every edge mode and both transition directions checks the captured value against the bench's own copy of the count. The same sweep also checks that the other three registers did not move.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   // per-channel nibble inside a pair control word
   localparam int NIB_W     = 4;
   localparam int NIB_EN    = 2;
   localparam int NIB_FLAG  = 3;
   localparam int CH_PER_WORD = 2;
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ecap_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ecap_edge_detect.sv
module ecap_edge_detect
   import ecap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  edge_mode_e mode,
   output logic       hit
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   logic rise, fall;
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   always_comb begin
      unique case (mode)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ecap_channel.sv
module ecap_channel
   import ecap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  edge_mode_e       mode,
   input  logic [CNT_W-1:0] timebase,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cap,
   output logic             flag,
   output logic             hit
);
   logic pin_s;

   ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
   );

   ecap_edge_detect u_det (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s), .mode(mode), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap  <= '0;
         flag <= 1'b0;
      end else begin
         if (hit) cap <= timebase;
         if (hit)           flag <= 1'b1;   // capture wins over clear
         else if (flag_clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
   import ecap_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  timebase,
   input  logic [NUM_CH-1:0] cap_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int PAIRS     = NUM_CH / CH_PER_WORD;
   localparam int DATA_BASE = PAIRS;
   localparam int N_ADDR    = PAIRS + NUM_CH;

   generate
      if (NUM_CH % CH_PER_WORD != 0) begin : g_bad_ch
         $error("edge_capture_unit: NUM_CH must be even");
      end
      if (CNT_W < CH_PER_WORD * NIB_W) begin : g_bad_w
         $error("edge_capture_unit: CNT_W too narrow for a control word");
      end
      if ((1 << ADDR_W) < N_ADDR) begin : g_bad_a
         $error("edge_capture_unit: ADDR_W too small for the register map");
      end
   endgenerate

   logic [NUM_CH-1:0][1:0]       mode_q;
   logic [NUM_CH-1:0]            en_q;
   logic [NUM_CH-1:0]            flag;
   logic [NUM_CH-1:0]            flag_clr;
   logic [NUM_CH-1:0]            hit;
   logic [NUM_CH-1:0][CNT_W-1:0] cap_q;

   genvar p, k;
   generate
      for (p = 0; p < PAIRS; p++) begin : g_pair
         logic wr_pair;
         assign wr_pair = wr_en && (addr == ADDR_W'(p));
         for (k = 0; k < CH_PER_WORD; k++) begin : g_ch
            localparam int C  = p * CH_PER_WORD + k;
            localparam int LO = k * NIB_W;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  mode_q[C] <= EDGE_OFF;
                  en_q[C]   <= 1'b0;
               end else if (wr_pair) begin
                  mode_q[C] <= wdata[LO +: 2];
                  en_q[C]   <= wdata[LO + NIB_EN];
               end
            end

            assign flag_clr[C] = wr_pair & ~wdata[LO + NIB_FLAG];

            ecap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
               .clk      (clk),
               .rst_n    (rst_n),
               .pin      (cap_in[C]),
               .mode     (edge_mode_e'(mode_q[C])),
               .timebase (timebase),
               .flag_clr (flag_clr[C]),
               .cap      (cap_q[C]),
               .flag     (flag[C]),
               .hit      (hit[C])
            );
         end
      end
   endgenerate

   assign irq = flag & en_q;

   always_comb begin
      rdata = '0;
      for (int pi = 0; pi < PAIRS; pi++) begin
         if (addr == ADDR_W'(pi)) begin
            for (int ki = 0; ki < CH_PER_WORD; ki++) begin
               rdata[ki*NIB_W +: NIB_W] = {flag[pi*CH_PER_WORD+ki],
                                           en_q[pi*CH_PER_WORD+ki],
                                           mode_q[pi*CH_PER_WORD+ki]};
            end
         end
      end
      for (int ci = 0; ci < NUM_CH; ci++) begin
         if (addr == ADDR_W'(DATA_BASE + ci)) rdata = cap_q[ci];
      end
   end
endmodule

// File: rtl/ecap_checker.sv
module ecap_checker #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [CNT_W-1:0]            timebase,
   input logic [NUM_CH-1:0]           hit,
   input logic [NUM_CH-1:0]           flag,
   input logic [NUM_CH-1:0]           flag_clr,
   input logic [NUM_CH-1:0][1:0]      mode_q,
   input logic [NUM_CH-1:0][CNT_W-1:0] cap_q
);
   genvar i;
   generate
      for (i = 0; i < NUM_CH; i++) begin : g_chk
         p_off_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] == 2'b00) |-> !hit[i]);

         p_capture_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> (cap_q[i] == $past(timebase)));

         p_cap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[i] |=> $stable(cap_q[i]));

         p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(hit[i]));

         p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !flag_clr[i]) |=> flag[i]);

         p_capture_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && flag_clr[i]) |=> flag[i]);
      end
   endgenerate
endmodule

bind edge_capture_unit ecap_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .timebase (timebase),
   .hit      (hit),
   .flag     (flag),
   .flag_clr (flag_clr),
   .mode_q   (mode_q),
   .cap_q    (cap_q)
);

// File: tb/tb_edge_capture_unit.sv
module tb_edge_capture_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timebase;
   logic [3:0]  cap_in = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_err = 0;

   logic [1:0] sh_mode [4];
   logic       sh_en   [4];

   edge_capture_unit dut (
      .clk(clk), .rst_n(rst_n), .timebase(timebase), .cap_in(cap_in),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) timebase <= 16'h1230;
      else        timebase <= timebase + 16'd1;
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      @(negedge clk);
      addr = 3'(a);
      #1 v = rdata;
   endtask

   function automatic logic [15:0] ctrl_w(input int p, input logic [1:0] clr);
      logic [15:0] w = '0;
      for (int k = 0; k < 2; k++)
         w[4*k +: 4] = {~clr[k], sh_en[2*p+k], sh_mode[2*p+k]};
      return w;
   endfunction

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_n(input int n);
      for (int j = 0; j < n; j++) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] v, prev, t, ctl;
      logic [15:0] others [4];
      for (int c = 0; c < 4; c++) begin sh_mode[c] = 2'b00; sh_en[c] = 1'b0; end
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         chk("R1 reset readback", v, 16'h0000);
      end
      chk("R1 reset irq", {12'h0, irq}, 16'h0000);

      // Sweep: R2 R3 R4 R5 R6 R7 R12 over channel x mode x direction
      for (int ch = 0; ch < 4; ch++) begin
         for (int m = 0; m < 4; m++) begin
            for (int dir = 0; dir < 2; dir++) begin
               logic start, active;
               int p, nib;
               p = ch / 2; nib = ch % 2;
               start = (dir == 0) ? 1'b0 : 1'b1;
               cap_in[ch] = start;
               wait_n(4);
               sh_mode[ch] = 2'(m); sh_en[ch] = 1'b1;
               wr(p, ctrl_w(p, 2'b11));
               rd(2 + ch, prev);
               for (int o = 0; o < 4; o++) rd(2 + o, others[o]);
               @(negedge clk);
               t = timebase;
               cap_in[ch] = ~start;
               wait_n(5);
               active = (m == 3) || (m == 1 && dir == 0) || (m == 2 && dir == 1);
               rd(2 + ch, v);
               if (m == 0)        chk("R5 disabled keeps data", v, prev);
               else if (m == 1)   chk("R2 rising mode data / R6 latency", v, active ? t + 16'd2 : prev);
               else if (m == 2)   chk("R3 falling mode data / R6 latency", v, active ? t + 16'd2 : prev);
               else               chk("R4 both-edge mode data / R6 latency", v, t + 16'd2);
               rd(p, ctl);
               chk("R7 flag after edge", {15'h0, ctl[4*nib+3]}, {15'h0, active});
               chk("R7 irq with enable", {15'h0, irq[ch]}, {15'h0, active});
               for (int o = 0; o < 4; o++) begin
                  if (o != ch) begin
                     rd(2 + o, v);
                     chk("R12 other channel untouched", v, others[o]);
                  end
               end
               sh_mode[ch] = 2'b00; sh_en[ch] = 1'b0;
               wr(p, ctrl_w(p, 2'b11));
            end
         end
      end
      cap_in = '0;
      wait_n(4);

      // R7: enable gating of irq on channel 1
      sh_mode[1] = 2'b01; sh_en[1] = 1'b0;
      wr(0, ctrl_w(0, 2'b11));
      cap_in[1] = 1'b1;
      wait_n(5);
      rd(0, ctl);
      chk("R7 flag set with enable off", {15'h0, ctl[7]}, 16'h0001);
      chk("R7 irq masked", {15'h0, irq[1]}, 16'h0000);
      sh_en[1] = 1'b1;
      wr(0, ctrl_w(0, 2'b00));   // writing 1 to flag bits
      wait_n(1);
      chk("R8 write of 1 keeps flag / R7 irq on", {15'h0, irq[1]}, 16'h0001);
      wr(0, ctrl_w(0, 2'b10));   // clear channel 1 only
      wait_n(1);
      rd(0, ctl);
      chk("R8 clear by writing 0", {15'h0, ctl[7]}, 16'h0000);
      chk("R7 irq drops after clear", {15'h0, irq[1]}, 16'h0000);

      // R9: overwrite while flag set
      @(negedge clk); t = timebase; cap_in[1] = 1'b0; cap_in[1] = 1'b1;
      cap_in[1] = 1'b0;
      wait_n(3);
      @(negedge clk); t = timebase; cap_in[1] = 1'b1;
      wait_n(5);
      rd(3, v);
      chk("R9 first capture", v, t + 16'd2);
      @(negedge clk); cap_in[1] = 1'b0;
      wait_n(3);
      @(negedge clk); t = timebase; cap_in[1] = 1'b1;
      wait_n(5);
      rd(3, v);
      chk("R9 overwrite with flag set", v, t + 16'd2);

      // R8: capture and clear in the same clock (channel 0, both edges)
      sh_mode[0] = 2'b11; sh_en[0] = 1'b1;
      wr(0, ctrl_w(0, 2'b11));
      cap_in[0] = 1'b1;
      wait_n(5);
      @(negedge clk); t = timebase; cap_in[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'd0; wdata = ctrl_w(0, 2'b01);
      @(negedge clk);
      wr_en = 1'b0;
      rd(0, ctl);
      chk("R8 capture wins over clear", {15'h0, ctl[3]}, 16'h0001);
      rd(2, v);
      chk("R8 capture during clear stores data", v, t + 16'd2);

      // R10 / R11: map and read-only data
      sh_mode[2] = 2'b11; sh_en[2] = 1'b1; sh_mode[3] = 2'b11; sh_en[3] = 1'b1;
      rd(4, prev);
      wr(1, 16'hFF77);
      rd(1, v);
      chk("R10 control word layout, upper bits zero", v, 16'h0077);
      wr(4, 16'hFFFF);
      rd(4, v);
      chk("R11 write to data address ignored", v, prev);
      rd(1, v);
      chk("R11 data write leaves control intact", v, 16'h0077);
      rd(6, v);
      chk("R11 unused address 6", v, 16'h0000);
      rd(7, v);
      chk("R11 unused address 7", v, 16'h0000);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule